// File: doc/BRIEF.md
# Parallel ADC Host Controller

This block sits on the host side of a sampling ADC that has a byte-wide, three-state parallel data bus. A conversion starts either from a one-cycle request pulse or from an internal sample-rate timer. The block drives the convert-start line and waits for the converter's busy flag to drop. It then runs two chip-select/read cycles, which fetch the 10-bit result as an upper byte and then a lower byte. The assembled sample appears on a data output together with a one-cycle valid strobe.

The converter's power state depends on the level of convert-start when a conversion finishes. A mode input chooses between two behaviours. In power-down mode the converter sleeps between samples. Each sample then opens with a wake-up pulse on convert-start, and convert-start is held low through the conversion. In stay-powered mode convert-start rests high and returns high before busy drops. Every interface interval is given in nanoseconds and converted to clock cycles from the system clock frequency. These intervals are the wake-up time, the minimum low pulse, the read access time, the spacing between the two reads, the recovery gap and the busy timeout.

Top module: `adc_host_ctrl`

## Requirements
- R1: While rst_ni is low, convst_o is 0, cs_no and rd_no are 1, and sample_valid_o and timeout_o are 0.
- R2: With pwr_down_mode_i = 1 at the start of a sample, convst_o is high for at least the wake-up time (1.5 us) before it falls. It then stays low until busy_i has fallen, so the converter powers down after the conversion.
- R3: With pwr_down_mode_i = 0, convst_o is high when busy_i falls and stays high between samples. Once the converter is awake, a new request produces a convert-start falling edge within two cycles, with no new wake-up pulse.
- R4: Every low pulse on convst_o that ends in a rising edge lasts at least 20 ns.
- R5: A read never starts while busy_i is high. Reads start only after busy_i has been seen to rise and then fall.
- R6: In each read, cs_no is low whenever rd_no is low, and cs_no never rises before rd_no. rd_no stays low for at least the access time (10 ns) plus one clock.
- R7: Each sample uses exactly two reads. The first returns the upper byte and the second the lower byte. rd_no stays high for at least 10 ns between the two reads.
- R8: sample_o[9:2] holds the first byte read and sample_o[1:0] holds bits 7:6 of the second byte. The other bits of the second byte are discarded. sample_valid_o is high for exactly one cycle per completed sample.
- R9: A falling edge on convst_o comes at least 50 ns after the last rising edge of cs_no or rd_no.
- R10: If busy_i has not fallen within 3 us of the convert-start falling edge, timeout_o pulses for one cycle, no read is performed, no sample is delivered, and the controller becomes ready for the next request.
- R11: A sample_req_i pulse while idle starts exactly one sample. A request that arrives while a sample is in progress is dropped. While auto_en_i = 1, samples start every 1/SAMPLE_HZ seconds, exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_down_mode_i | input | 1 | 1: power down between samples, 0: stay powered; latched at sample start |
| auto_en_i | input | 1 | Enables the internal sample-rate timer |
| sample_req_i | input | 1 | One-cycle request for a single sample |
| busy_i | input | 1 | Converter busy flag (asynchronous, synchronized inside) |
| data_i | input | 8 | Converter data bus |
| convst_o | output | 1 | Convert-start line |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| sample_o | output | 10 | Last assembled sample |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample_o |
| timeout_o | output | 1 | One-cycle strobe when busy did not fall in time |

## Verification
A corrupted state register or phase counter shows up at the pins within one sample. It can appear as a convert-start edge too close to the last read, a wake-up pulse that is too short, or a read that starts while the busy flag is still high. It can also appear as a third read or a missing read, which shifts the bytes and breaks the assembled word at the very next valid strobe. A wrong power-mode decision shows at the busy falling edge as the wrong convert-start level. A broken timeout path shows as a missing strobe about 3 us after convert-start falls, or as reads issued against a hung converter.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_CNV_LO,
    ST_CNV_WAIT,
    ST_RD_HI,
    ST_GAP,
    ST_RD_LO,
    ST_RECOVER
  } state_e;

  // Round a time in ns up to whole clock cycles, at least one.
  function automatic int unsigned ns2cyc(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_host_dcnt.sv
module adc_host_dcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else begin
        sr_q[0] <= d_i;
        for (int i = 1; i < int'(STAGES); i++) sr_q[i] <= sr_q[i-1];
      end
    end
    assign q_o = sr_q[STAGES-1];
  end
endmodule

// File: rtl/adc_host_rate.sv
module adc_host_rate #(
  parameter int unsigned PERIOD = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_host_pack.sv
module adc_host_pack #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RES_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cap_hi_i,
  input  logic              cap_lo_i,
  input  logic              done_i,
  output logic [RES_W-1:0]  sample_o,
  output logic              valid_o
);
  localparam int unsigned LO_W = RES_W - DATA_W;

  logic [DATA_W-1:0] hi_q;
  logic [RES_W-1:0]  word_q;
  logic              valid_q;
  logic              unused_lo;

  // only the top LO_W bits of the second byte carry result bits
  assign unused_lo = ^data_i[DATA_W-LO_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cap_hi_i) hi_q   <= data_i;
      if (cap_lo_i) word_q <= {hi_q, data_i[DATA_W-1 -: LO_W]};
      valid_q <= done_i;
    end
  end

  assign sample_o = word_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 250_000_000,
  parameter int unsigned SAMPLE_HZ    = 100_000,
  parameter int unsigned WAKE_NS      = 1500,
  parameter int unsigned CONVST_LO_NS = 20,
  parameter int unsigned ACCESS_NS    = 10,
  parameter int unsigned READ_GAP_NS  = 10,
  parameter int unsigned RECOVER_NS   = 50,
  parameter int unsigned TIMEOUT_NS   = 3000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RES_W        = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_down_mode_i,
  input  logic              auto_en_i,
  input  logic              sample_req_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              convst_o,
  output logic              cs_no,
  output logic              rd_no,
  output logic [RES_W-1:0]  sample_o,
  output logic              sample_valid_o,
  output logic              timeout_o
);
  localparam int unsigned WAKE_C = ns2cyc(WAKE_NS, CLK_HZ);
  localparam int unsigned LO_C   = ns2cyc(CONVST_LO_NS, CLK_HZ);
  localparam int unsigned ACC_C  = ns2cyc(ACCESS_NS, CLK_HZ) + 1;
  localparam int unsigned GAP_C  = ns2cyc(READ_GAP_NS, CLK_HZ);
  localparam int unsigned REC_C  = ns2cyc(RECOVER_NS, CLK_HZ);
  localparam int unsigned TMO_C  = ns2cyc(TIMEOUT_NS, CLK_HZ);
  localparam int unsigned RATE_C = CLK_HZ / SAMPLE_HZ;
  localparam int unsigned PH_MAX = umax(umax(WAKE_C, LO_C), umax(umax(ACC_C, GAP_C), REC_C));
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam int unsigned TMO_W  = $clog2(TMO_C + 1);

  state_e            state_q, state_d;
  logic              mode_pd_q, awake_q, seen_q, tmo_q;
  logic              busy_s, tick, start;
  logic              ph_load, ph_zero, tmo_load, tmo_zero;
  logic [PH_W-1:0]   ph_val;
  logic              cap_hi, cap_lo, done, tmo_hit, conv_end;

  adc_host_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(busy_i), .q_o(busy_s)
  );

  adc_host_rate #(.PERIOD(RATE_C)) u_rate (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(auto_en_i), .tick_o(tick)
  );

  adc_host_dcnt #(.W(PH_W)) u_phase (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(ph_load), .val_i(ph_val), .zero_o(ph_zero)
  );

  adc_host_dcnt #(.W(TMO_W)) u_tmo (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(tmo_load),
    .val_i (TMO_W'(TMO_C - 1)), .zero_o(tmo_zero)
  );

  adc_host_pack #(.DATA_W(DATA_W), .RES_W(RES_W)) u_pack (
    .clk_i   (clk_i), .rst_ni(rst_ni), .data_i(data_i),
    .cap_hi_i(cap_hi), .cap_lo_i(cap_lo), .done_i(done),
    .sample_o(sample_o), .valid_o(sample_valid_o)
  );

  assign start = sample_req_i | tick;

  always_comb begin
    state_d  = state_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    tmo_load = 1'b0;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    done     = 1'b0;
    tmo_hit  = 1'b0;
    conv_end = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        if (pwr_down_mode_i || !awake_q) begin
          state_d = ST_WAKE;
          ph_load = 1'b1;
          ph_val  = PH_W'(WAKE_C - 1);
        end else begin
          state_d  = ST_CNV_LO;
          ph_load  = 1'b1;
          ph_val   = PH_W'(LO_C - 1);
          tmo_load = 1'b1;
        end
      end
      ST_WAKE: if (ph_zero) begin
        state_d  = ST_CNV_LO;
        ph_load  = 1'b1;
        ph_val   = PH_W'(LO_C - 1);
        tmo_load = 1'b1;
      end
      ST_CNV_LO: if (ph_zero) state_d = ST_CNV_WAIT;
      ST_CNV_WAIT: begin
        if (seen_q && !busy_s) begin
          state_d  = ST_RD_HI;
          ph_load  = 1'b1;
          ph_val   = PH_W'(ACC_C - 1);
          conv_end = 1'b1;
        end else if (tmo_zero) begin
          state_d  = ST_IDLE;
          tmo_hit  = 1'b1;
          conv_end = 1'b1;
        end
      end
      ST_RD_HI: if (ph_zero) begin
        state_d = ST_GAP;
        ph_load = 1'b1;
        ph_val  = PH_W'(GAP_C - 1);
        cap_hi  = 1'b1;
      end
      ST_GAP: if (ph_zero) begin
        state_d = ST_RD_LO;
        ph_load = 1'b1;
        ph_val  = PH_W'(ACC_C - 1);
      end
      ST_RD_LO: if (ph_zero) begin
        state_d = ST_RECOVER;
        ph_load = 1'b1;
        ph_val  = PH_W'(REC_C - 1);
        cap_lo  = 1'b1;
      end
      ST_RECOVER: if (ph_zero) begin
        state_d = ST_IDLE;
        done    = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_pd_q <= 1'b1;
      awake_q   <= 1'b0;
      seen_q    <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_hit;
      if (state_q == ST_IDLE && start) mode_pd_q <= pwr_down_mode_i;
      // convst level at conversion end decides whether the converter stays up
      if (conv_end) awake_q <= !mode_pd_q;
      if (state_q == ST_CNV_LO || state_q == ST_CNV_WAIT) seen_q <= seen_q | busy_s;
      else                                                 seen_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_WAKE:     convst_o = 1'b1;
      ST_CNV_LO:   convst_o = 1'b0;
      ST_CNV_WAIT: convst_o = !mode_pd_q;
      default:     convst_o = !mode_pd_q && awake_q;
    endcase
  end

  // chip select and read share one edge: zero setup and hold are allowed
  assign rd_no     = !(state_q == ST_RD_HI || state_q == ST_RD_LO);
  assign cs_no     = rd_no;
  assign timeout_o = tmo_q;

endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk
  import adc_host_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 250_000_000,
  parameter int unsigned CONVST_LO_NS = 20,
  parameter int unsigned RECOVER_NS   = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic convst_o,
  input logic cs_no,
  input logic rd_no,
  input logic busy_i,
  input logic sample_valid_o,
  input logic timeout_o
);
  localparam int unsigned LO_C  = ns2cyc(CONVST_LO_NS, CLK_HZ);
  localparam int unsigned REC_C = ns2cyc(RECOVER_NS, CLK_HZ);

  int unsigned lo_run_q, since_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q   <= LO_C;
      since_rd_q <= REC_C;
    end else begin
      if (convst_o)             lo_run_q <= 0;
      else if (lo_run_q < LO_C) lo_run_q <= lo_run_q + 1;
      if (!cs_no || !rd_no)         since_rd_q <= 0;
      else if (since_rd_q < REC_C)  since_rd_q <= since_rd_q + 1;
    end
  end

  p_rd_inside_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !cs_no);

  p_cs_after_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> rd_no);

  p_no_read_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> !busy_i);

  p_lo_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convst_o) |-> lo_run_q >= LO_C);

  p_recovery_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convst_o) |-> since_rd_q >= REC_C);

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);

  p_timeout_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (cs_no && rd_no && !sample_valid_o));

endmodule

bind adc_host_ctrl adc_host_chk #(
  .CLK_HZ(CLK_HZ), .CONVST_LO_NS(CONVST_LO_NS), .RECOVER_NS(RECOVER_NS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .convst_o(convst_o), .cs_no(cs_no), .rd_no(rd_no),
  .busy_i(busy_i), .sample_valid_o(sample_valid_o), .timeout_o(timeout_o)
);

// File: tb/tb_adc_host_ctrl.sv
`timescale 1ns/1ps
module tb_adc_host_ctrl;
  // cycle counts at 250 MHz (4 ns)
  localparam int WAKE_C = 375;
  localparam int LO_C   = 5;
  localparam int ACC_C  = 4;
  localparam int GAP_C  = 3;
  localparam int REC_C  = 13;
  localparam int TMO_C  = 750;
  localparam int RATE_C = 2500;
  localparam int CONV_C = 100;
  localparam int BIG    = 100000;

  logic clk = 0;
  logic rst_n = 0;
  logic mode = 1, auto_en = 0, req = 0, busy = 0;
  logic [7:0] data = 8'h00;
  logic convst, cs_n, rd_n, valid, tmo;
  logic [9:0] sample;

  always #2 clk = ~clk;

  adc_host_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_down_mode_i(mode), .auto_en_i(auto_en),
    .sample_req_i(req), .busy_i(busy), .data_i(data), .convst_o(convst),
    .cs_no(cs_n), .rd_no(rd_n), .sample_o(sample), .sample_valid_o(valid),
    .timeout_o(tmo)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int stuck = 0;
  int exp_mode = 1;
  logic [9:0] stim_val = '0, conv_val = '0;
  int conv_mode = 1;
  int n_falls = 0, n_valid = 0, n_tmo = 0, n_rdfall = 0;
  int fall_cyc = 0, tmo_cyc = 0;
  int fall_hist [4];
  bit adc_pwr = 0;

  task automatic chk(input bit ok, input string req_s, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req_s, act, exp);
    end
  endtask

  // converter model and port monitor
  int hi_run = 0, lo_run = 0, conv_t = BIG, rd_lo = 0, rd_gap = 0, since_cs = BIG, reads = 0;
  logic p_cv = 0, p_rd = 1, p_cs = 1, p_valid = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_cv && !convst) begin
        n_falls++;
        fall_cyc = cyc;
        fall_hist[n_falls % 4] = cyc;
        chk(since_cs >= REC_C, "R9 recovery before convst fall", since_cs, REC_C);
        if (!adc_pwr) chk(hi_run >= WAKE_C, "R2 wake-up high time", hi_run, WAKE_C);
        conv_val  = stim_val;
        conv_mode = exp_mode;
        reads     = 0;
        conv_t    = 0;
      end
      if (!p_cv && convst) chk(lo_run >= LO_C, "R4 convst low width", lo_run, LO_C);
      hi_run = convst ? hi_run + 1 : 0;
      lo_run = convst ? 0 : lo_run + 1;

      if (stuck == 1)      busy = 1'b0;
      else if (stuck == 2) busy = (conv_t >= 2 && conv_t < BIG);
      else                 busy = (conv_t >= 2 && conv_t < 2 + CONV_C);
      if (stuck == 0 && conv_t == 2 + CONV_C) begin
        adc_pwr = convst;
        if (conv_mode == 1) chk(convst == 1'b0, "R2 convst low at busy fall", convst, 0);
        else                chk(convst == 1'b1, "R3 convst high at busy fall", convst, 1);
      end
      if (conv_t < BIG) conv_t++;

      if (p_rd && !rd_n) begin
        n_rdfall++;
        chk(!cs_n, "R6 cs low at rd fall", cs_n, 0);
        chk(!busy && conv_t > 2 + CONV_C, "R5 read after busy fall", busy, 0);
        if (reads == 1) chk(rd_gap >= GAP_C, "R7 gap between reads", rd_gap, GAP_C);
        chk(reads < 2, "R7 two reads per sample", reads + 1, 2);
        rd_lo = 0;
      end
      if (!p_rd && rd_n) begin
        chk(rd_lo >= ACC_C, "R6 rd low width", rd_lo, ACC_C);
        reads++;
        rd_gap = 0;
      end
      if (!rd_n && cs_n) chk(0, "R6 cs high while rd low", cs_n, 0);
      if (!rd_n) rd_lo++; else rd_gap++;
      if (!p_cs && cs_n) since_cs = 0; else if (since_cs < BIG) since_cs++;

      if (!cs_n && !rd_n && rd_lo >= 2)
        data = (reads == 0) ? conv_val[9:2] : {conv_val[1:0], 6'b101101};
      else
        data = 8'h5A ^ cyc[7:0];

      if (valid) begin
        n_valid++;
        chk(sample == conv_val, "R8 assembled sample", sample, conv_val);
        chk(reads == 2, "R7 reads before valid", reads, 2);
      end
      if (p_valid && valid) chk(0, "R8 valid wider than one cycle", 2, 1);
      if (tmo) begin n_tmo++; tmo_cyc = cyc; end
    end
    p_cv = convst; p_rd = rd_n; p_cs = cs_n; p_valid = valid;
  end

  task automatic do_sample(input int m, input logic [9:0] v, input bit awake_chk);
    int nv0, nf0, w, rc;
    nv0 = n_valid; nf0 = n_falls;
    mode = m[0]; exp_mode = m; stim_val = v;
    @(negedge clk); req = 1; rc = cyc;
    @(negedge clk); req = 0;
    w = 0;
    while (n_valid == nv0 && w < 3000) begin @(negedge clk); w++; end
    chk(n_valid == nv0 + 1, "R11 request gives one sample", n_valid - nv0, 1);
    chk(n_falls == nf0 + 1, "R11 one convert start", n_falls - nf0, 1);
    if (m == 1) chk(fall_cyc - rc >= WAKE_C, "R2 wake before start", fall_cyc - rc, WAKE_C);
    if (m == 0) chk(convst == 1'b1, "R3 convst rests high", convst, 1);
    if (awake_chk) chk(fall_cyc - rc <= 2, "R3 no re-wake when powered", fall_cyc - rc, 2);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int nv0, nf0, nt0, nr0, w;
    repeat (4) @(negedge clk);
    chk(convst == 0, "R1 reset convst", convst, 0);
    chk(cs_n == 1 && rd_n == 1, "R1 reset cs/rd", {cs_n, rd_n}, 3);
    chk(valid == 0 && tmo == 0, "R1 reset strobes", {valid, tmo}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 16; i++)
      do_sample(1, (i == 15) ? 10'h3FF : 10'((i * 67) % 1024), 0);

    for (int k = 0; k < 256; k++)
      do_sample(0, 10'(k * 4 + k % 4), k > 0);

    // dropped request during a conversion
    nv0 = n_valid; nf0 = n_falls;
    exp_mode = 0; mode = 0; stim_val = 10'h2C3;
    @(negedge clk); req = 1; @(negedge clk); req = 0;
    w = 0; while (!busy && w < 500) begin @(negedge clk); w++; end
    req = 1; @(negedge clk); req = 0;
    repeat (800) @(negedge clk);
    chk(n_falls == nf0 + 1, "R11 busy-time request dropped", n_falls - nf0, 1);
    chk(n_valid == nv0 + 1, "R11 one sample after drop", n_valid - nv0, 1);

    // timer-driven sampling
    nf0 = n_falls; stim_val = 10'h1E7;
    auto_en = 1;
    w = 0; while (n_falls < nf0 + 4 && w < 12000) begin @(negedge clk); w++; end
    auto_en = 0;
    chk(n_falls >= nf0 + 4, "R11 auto samples", n_falls - nf0, 4);
    for (int k = 1; k < 4; k++)
      chk(fall_hist[(nf0 + k + 1) % 4] - fall_hist[(nf0 + k) % 4] == RATE_C, "R11 auto period",
          fall_hist[(nf0 + k + 1) % 4] - fall_hist[(nf0 + k) % 4], RATE_C);
    repeat (400) @(negedge clk);

    // busy never rises, then busy never falls
    for (int kind = 1; kind <= 2; kind++) begin
      nt0 = n_tmo; nv0 = n_valid; nr0 = n_rdfall;
      mode = 0; exp_mode = 0; stuck = kind;
      @(negedge clk); req = 1; @(negedge clk); req = 0;
      w = 0; while (n_tmo == nt0 && w < 2000) begin @(negedge clk); w++; end
      chk(n_tmo == nt0 + 1, "R10 timeout strobe", n_tmo - nt0, 1);
      chk(tmo_cyc - fall_cyc >= TMO_C - 2 && tmo_cyc - fall_cyc <= TMO_C + 2,
          "R10 timeout delay", tmo_cyc - fall_cyc, TMO_C);
      repeat (5) @(negedge clk);
      chk(n_rdfall == nr0, "R10 no read after timeout", n_rdfall - nr0, 0);
      chk(n_valid == nv0, "R10 no sample after timeout", n_valid - nv0, 0);
      stuck = 0;
      repeat (20) @(negedge clk);
      do_sample(0, 10'h155 + 10'(kind), 0);
    end

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule